// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block keeps a 19-bit channel-enable mask in a 32-bit register and walks an external converter through every enabled input, one input at a time. Software sets the mask through a simple write strobe with write data and reads it back on a read-data bus. A single-cycle start pulse begins a scan. The scan runs upward or downward through the channel indices, and a scan-direction input selects which. Each enabled channel becomes one conversion request on a valid/ready output. The converter raises ready when that conversion is finished. A one-cycle end-of-scan pulse marks the end of the pass.

Any change to the configuration clears a configuration-ready flag for a fixed settling time. A configuration change is an accepted mask write, a toggle of the mode input or a toggle of the direction input. While the flag is low, the block ignores further mask writes and start pulses. It also ignores mask writes while a scan is running. The mode input has no other effect.

Back-pressure rules for the request stream: `req_valid` stays high and `req_chan` holds its value until a cycle in which `req_ready` is high. That cycle completes the conversion of that channel. The next request, if there is one, appears on the following cycle. `req_ready` has no effect while `req_valid` is low.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, the read data is zero, `cfg_ready` is 1, and `busy`, `req_valid` and `eos` are 0.
- R2: Write data bits 18:0 are stored as the mask, where bit x enables channel x. Read-data bits 31:19 always read as zero.
- R3: A mask write presented while `busy` is 1 leaves the mask unchanged.
- R4: An accepted mask write, or a change on `mode_sel` or `scan_desc`, drives `cfg_ready` low on the next cycle. With no further change, `cfg_ready` rises again on the third cycle after the change was sampled, so it is low for two cycles.
- R5: A mask write presented while `cfg_ready` is 0 leaves the mask unchanged.
- R6: With `scan_desc` = 0, a started scan issues exactly one request for each enabled channel, in rising index order.
- R7: With `scan_desc` = 1, the requests come in falling index order. The direction is taken at the start of the scan.
- R8: While `req_valid` is 1 and `req_ready` is 0, `req_valid` stays 1 and `req_chan` does not change on the next cycle.
- R9: On the cycle after the handshake for the last enabled channel, `eos` is 1 for exactly one cycle and `busy` is already 0.
- R10: A start with an all-zero mask issues no request, leaves `busy` at 0 and raises `eos` on the next cycle.
- R11: A start given while `cfg_ready` is 0 is ignored: no request is issued, `busy` stays 0 and no `eos` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Mask register write strobe |
| reg_wdata | input | 32 | Write data; bits 18:0 form the mask |
| reg_rdata | output | 32 | Mask read-back, with the upper bits held at zero |
| mode_sel | input | 1 | Mode input; any change restarts configuration settling |
| scan_desc | input | 1 | 0 = scan in rising index order, 1 = scan in falling index order |
| start | input | 1 | Start pulse for a scan |
| busy | output | 1 | High while a scan is running |
| cfg_ready | output | 1 | High when the current configuration is accepted |
| req_valid | output | 1 | A conversion request is pending |
| req_ready | input | 1 | The converter finished the pending request |
| req_chan | output | 5 | Channel index of the pending request |
| eos | output | 1 | One-cycle end-of-scan pulse |

## Verification
The bench targets channels 0 and 18, because a window computed off by one at either end would drop them or loop past them. It runs both directions on the same mask, so a sequencer that ignored `scan_desc` would produce requests in the wrong order for the scoreboard. It stalls the converter for several cycles to catch a design that advances without the handshake or lets the channel index change while a request is held. It also sends a write inside the settling window, a write during a scan and a start during settling, which a design with missing gating would accept. Finally, it checks that an empty mask gives an immediate end-of-scan pulse rather than a hang or a stray request.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/adc_cfg_reg.sv
// Mask register with write gating and a configuration settling counter.
module adc_cfg_reg #(
  parameter int NCH     = 19,
  parameter int CFG_LAT = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [NCH-1:0] wr_data,
  input  logic           mode_sel,
  input  logic           scan_desc,
  input  logic           busy,
  output logic [NCH-1:0] mask,
  output logic           cfg_ready
);
  localparam int CW = $clog2(CFG_LAT + 1);

  logic [CW-1:0] settle_q;
  logic          mode_q, dir_q;
  logic          wr_ok, cfg_chg;

  assign cfg_ready = (settle_q == '0);
  assign wr_ok     = wr_en & ~busy & cfg_ready;
  assign cfg_chg   = wr_ok | (mode_sel ^ mode_q) | (scan_desc ^ dir_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask     <= '0;
      settle_q <= '0;
      mode_q   <= 1'b0;
      dir_q    <= 1'b0;
    end else begin
      mode_q <= mode_sel;
      dir_q  <= scan_desc;
      if (wr_ok) mask <= wr_data;
      if (cfg_chg)              settle_q <= CW'(CFG_LAT);
      else if (settle_q != '0)  settle_q <= settle_q - 1'b1;
    end
  end
endmodule

// File: rtl/adc_chan_pick.sv
// Chooses the lowest (rising scan) or highest (falling scan) candidate bit.
module adc_chan_pick #(
  parameter int NCH = 19,
  parameter int IW  = 5
) (
  input  logic [NCH-1:0] cand,
  input  logic           desc,
  output logic           found,
  output logic [IW-1:0]  idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    if (desc) begin
      for (int i = 0; i < NCH; i++) begin
        if (cand[i]) begin
          found = 1'b1;
          idx   = IW'(i);
        end
      end
    end else begin
      for (int i = NCH - 1; i >= 0; i--) begin
        if (cand[i]) begin
          found = 1'b1;
          idx   = IW'(i);
        end
      end
    end
  end
endmodule

// File: rtl/adc_scan_fsm.sv
// Scan control: start gating, channel stepping, request handshake, end pulse.
module adc_scan_fsm
  import adc_scan_pkg::*;
#(
  parameter int NCH = 19,
  parameter int IW  = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           cfg_ready,
  input  logic [NCH-1:0] mask,
  input  logic           scan_desc,
  input  logic           req_ready,
  output logic           busy,
  output logic           req_valid,
  output logic [IW-1:0]  req_chan,
  output logic           eos
);
  seq_state_e    st_q;
  logic [IW-1:0] chan_q;
  logic          dir_q, eos_q;
  logic [NCH-1:0] win, cand;
  logic          pick_found, start_ok, pick_desc;
  logic [IW-1:0] pick_idx;

  assign start_ok  = start & cfg_ready & (st_q == SEQ_IDLE);
  assign pick_desc = (st_q == SEQ_IDLE) ? scan_desc : dir_q;

  // Candidate window: everything at start, then only the channels past the current one.
  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      if (st_q == SEQ_IDLE) win[i] = 1'b1;
      else if (dir_q)       win[i] = (IW'(i) < chan_q);
      else                  win[i] = (IW'(i) > chan_q);
    end
  end
  assign cand = mask & win;

  adc_chan_pick #(.NCH(NCH), .IW(IW)) u_pick (
    .cand  (cand),
    .desc  (pick_desc),
    .found (pick_found),
    .idx   (pick_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      chan_q <= '0;
      dir_q  <= 1'b0;
      eos_q  <= 1'b0;
    end else begin
      eos_q <= 1'b0;
      case (st_q)
        SEQ_IDLE: begin
          if (start_ok) begin
            dir_q <= scan_desc;
            if (pick_found) begin
              st_q   <= SEQ_RUN;
              chan_q <= pick_idx;
            end else begin
              eos_q <= 1'b1;
            end
          end
        end
        default: begin
          if (req_ready) begin
            if (pick_found) begin
              chan_q <= pick_idx;
            end else begin
              st_q  <= SEQ_IDLE;
              eos_q <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign busy      = (st_q == SEQ_RUN);
  assign req_valid = (st_q == SEQ_RUN);
  assign req_chan  = chan_q;
  assign eos       = eos_q;
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NCH     = 19,
  parameter int REG_W   = 32,
  parameter int CFG_LAT = 2,
  parameter int IW      = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             mode_sel,
  input  logic             scan_desc,
  input  logic             start,
  output logic             busy,
  output logic             cfg_ready,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [IW-1:0]    req_chan,
  output logic             eos
);
  logic [NCH-1:0] mask;
  logic           unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[REG_W-1:NCH];

  adc_cfg_reg #(.NCH(NCH), .CFG_LAT(CFG_LAT)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr),
    .wr_data   (reg_wdata[NCH-1:0]),
    .mode_sel  (mode_sel),
    .scan_desc (scan_desc),
    .busy      (busy),
    .mask      (mask),
    .cfg_ready (cfg_ready)
  );

  adc_scan_fsm #(.NCH(NCH), .IW(IW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cfg_ready (cfg_ready),
    .mask      (mask),
    .scan_desc (scan_desc),
    .req_ready (req_ready),
    .busy      (busy),
    .req_valid (req_valid),
    .req_chan  (req_chan),
    .eos       (eos)
  );

  assign reg_rdata = {{(REG_W - NCH){1'b0}}, mask};
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
  parameter int NCH   = 19,
  parameter int REG_W = 32,
  parameter int IW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [REG_W-1:0] reg_rdata,
  input logic             start,
  input logic             busy,
  input logic             cfg_ready,
  input logic             req_valid,
  input logic             req_ready,
  input logic [IW-1:0]    req_chan,
  input logic             eos
);
  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[REG_W-1:NCH] == '0);

  // R3
  busy_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(reg_rdata));

  // R4
  wr_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !busy && cfg_ready) |=> !cfg_ready);

  // R5
  settle_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ready |=> $stable(reg_rdata));

  // R6
  req_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> reg_rdata[req_chan]);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_chan)));

  // R9
  eos_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eos |-> !busy);

  // R9
  eos_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eos |=> !eos);

  // R11
  start_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !cfg_ready && !busy) |=> (!busy && !eos));
endmodule

bind adc_scan_seq adc_scan_chk #(.NCH(NCH), .REG_W(REG_W), .IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_rdata (reg_rdata),
  .start     (start),
  .busy      (busy),
  .cfg_ready (cfg_ready),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_chan  (req_chan),
  .eos       (eos)
);

// File: tb/sim_adc_scan_seq.sv
`timescale 1ns/1ps
module sim_adc_scan_seq;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0, mode_sel = 1'b0, scan_desc = 1'b0;
  logic        start = 1'b0, req_ready = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        busy, cfg_ready, req_valid, eos;
  logic [4:0]  req_chan;

  int n_chk = 0, n_fail = 0;
  int exp_q[$];
  int stub_lat = 0, wait_cnt = 0, eos_cnt = 0;
  logic chk_eos_hi = 1'b0, chk_eos_lo = 1'b0, prev_stall = 1'b0;
  logic [4:0] prev_chan = '0;

  always #10 clk = ~clk;   // 50 MHz

  adc_scan_seq u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mode_sel(mode_sel), .scan_desc(scan_desc),
    .start(start), .busy(busy), .cfg_ready(cfg_ready), .req_valid(req_valid),
    .req_ready(req_ready), .req_chan(req_chan), .eos(eos)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Converter stub: raises ready after stub_lat stalled cycles.
  always begin
    @(negedge clk);
    if (req_valid && !req_ready) begin
      if (wait_cnt >= stub_lat) begin
        req_ready = 1'b1;
        wait_cnt  = 0;
      end else begin
        wait_cnt++;
      end
    end else begin
      req_ready = 1'b0;
    end
  end

  // Monitor / scoreboard: samples mid low phase.
  always begin
    int e;
    @(negedge clk);
    #5;
    if (chk_eos_lo) begin
      check(eos == 1'b0, "R9 eos lasts one cycle", eos, 0);
      chk_eos_lo = 1'b0;
    end
    if (chk_eos_hi) begin
      check(eos && !busy, "R9 eos after last handshake", {eos, busy}, 2'b10);
      chk_eos_hi = 1'b0;
      chk_eos_lo = 1'b1;
    end
    if (req_valid && prev_stall)
      check(req_chan == prev_chan, "R8 channel held while stalled", req_chan, prev_chan);
    if (req_valid && req_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected request", req_chan, 5'h1f);
      end else begin
        e = exp_q.pop_front();
        check(req_chan == 5'(e), "R6/R7 request order", req_chan, e);
        if (exp_q.size() == 0) chk_eos_hi = 1'b1;
      end
    end
    prev_stall = req_valid && !req_ready;
    prev_chan  = req_chan;
    if (eos) eos_cnt++;
  end

  task automatic write_reg(input logic [31:0] d);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  // Driver: pushes expected channels, starts the scan, waits for its end.
  task automatic run_scan(input logic [18:0] m, input bit desc, input int lat, input bit wr_mid);
    int ev;
    stub_lat = lat;
    if (scan_desc != desc) begin
      @(negedge clk);
      scan_desc = desc;
      repeat (3) @(negedge clk);
    end
    write_reg({13'h0, m});
    repeat (3) @(negedge clk);
    if (desc) begin
      for (int i = 18; i >= 0; i--) if (m[i]) exp_q.push_back(i);
    end else begin
      for (int i = 0; i < 19; i++) if (m[i]) exp_q.push_back(i);
    end
    ev = eos_cnt;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (m == '0) begin
      #5;
      check(eos && !busy && !req_valid, "R10 empty mask ends at once",
            {eos, busy, req_valid}, 3'b100);
    end
    if (wr_mid) begin
      write_reg(32'h0000_0001);
      #5;
      check(reg_rdata == {13'h0, m}, "R3 write during scan ignored", reg_rdata, {13'h0, m});
    end
    wait (eos_cnt != ev);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R6 every enabled channel requested", exp_q.size(), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    int ev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #5;
    check(reg_rdata == 0 && cfg_ready && !busy && !req_valid && !eos, "R1 reset state",
          {reg_rdata[3:0], cfg_ready, busy, req_valid, eos}, 4'b1000);

    // R2 / R4: upper bits dropped; ready low for two cycles
    write_reg(32'hFFFF_FFFF);
    #5;
    check(reg_rdata == 32'h0007_FFFF, "R2 mask field and zero upper bits", reg_rdata, 32'h0007_FFFF);
    check(!cfg_ready, "R4 ready low after write (1)", cfg_ready, 0);
    @(negedge clk); #5;
    check(!cfg_ready, "R4 ready low after write (2)", cfg_ready, 0);
    @(negedge clk); #5;
    check(cfg_ready, "R4 ready back after two cycles", cfg_ready, 1);

    // R5: write during settling dropped
    write_reg(32'h0000_0123);
    write_reg(32'h0000_0456);
    repeat (3) @(negedge clk); #5;
    check(reg_rdata == 32'h0000_0123, "R5 write while settling ignored", reg_rdata, 32'h123);

    // R4: mode toggle and direction toggle
    @(negedge clk);
    mode_sel = 1'b1;
    @(negedge clk); #5;
    check(!cfg_ready, "R4 mode change drops ready", cfg_ready, 0);
    repeat (2) @(negedge clk); #5;
    check(cfg_ready, "R4 ready after mode change", cfg_ready, 1);
    @(negedge clk);
    scan_desc = 1'b1;
    @(negedge clk); #5;
    check(!cfg_ready, "R4 direction change drops ready", cfg_ready, 0);
    repeat (2) @(negedge clk); #5;
    check(cfg_ready, "R4 ready after direction change", cfg_ready, 1);

    // R6 / R7 / R8 / R9 scans
    run_scan(19'h4_0025, 1'b0, 0, 1'b0);
    run_scan(19'h4_0025, 1'b1, 2, 1'b0);
    run_scan(19'h4_0001, 1'b0, 1, 1'b0);
    run_scan(19'h4_0001, 1'b1, 0, 1'b0);
    run_scan(19'h7_FFFF, 1'b0, 0, 1'b0);
    run_scan(19'h0_00F0, 1'b0, 3, 1'b1);   // R3
    run_scan(19'h0_0000, 1'b0, 0, 1'b0);   // R10

    // R11: start inside settling window
    write_reg(32'h0000_0008);
    ev = eos_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #5;
    check(!busy && !req_valid, "R11 start while settling ignored", {busy, req_valid}, 0);
    repeat (4) @(negedge clk); #5;
    check(eos_cnt == ev && !busy, "R11 no end pulse after ignored start", eos_cnt - ev, 0);

    summary();
  end
endmodule